// File: doc/BRIEF.md
# Wait-Stated 16-Bit Peripheral Bus Bridge

This block connects a byte-wide processor bus to a slow, half-word-wide external peripheral bus such as a disk-card register interface. The system address decoder raises `cpu_sel` for any access inside a 256-byte window. The bridge then runs one fixed-length peripheral cycle. It raises `cpu_hold` to freeze the processor cycle until the peripheral data is ready, and drops it in the same cycle that the strobe goes inactive.

The window is split by `cpu_addr[7:6]` into four 64-byte regions, one sub-device select each. Bit 5 picks between a real peripheral access and the bridge's own byte-wide holding register. The holding register carries the upper half of the 16-bit data bus. A peripheral read leaves its upper byte there for the processor to fetch later. A processor write to the holding register supplies the upper byte of the next peripheral write.

The data bus is split into `pb_dq_o`, `pb_dq_i` and an output enable, so that the pad tristate sits outside the block. The processor side uses a hold handshake rather than valid/ready. It has no back-pressure other than `cpu_hold`: while hold is high, the processor keeps `cpu_sel`, address, direction and write data unchanged.

Top module: `pbus_bridge`

## Requirements
- R1: While the peripheral strobe is active, exactly one bit of `dev_sel` is high: bit `cpu_addr[7:6]` of the latched address (00 gives bit 0, 11 gives bit 3). At all other times `dev_sel` is 0.
- R2: While the strobe is active and the latched `cpu_addr[7:6]` is 00, the latched `cpu_addr[4]` picks the disk select line: 0 drives `ide_sel_n[0]` low and 1 drives `ide_sel_n[1]` low. In all other cases both lines are high.
- R3: An access with `cpu_addr[5]`=0 is a peripheral access, and `pb_reg` carries the latched `cpu_addr[4:0]` while the strobe is active. An access with `cpu_addr[5]`=1 targets the holding register: it runs no strobe and raises no hold.
- R4: The strobes are active low. A read (`cpu_rd`=1) drives `pb_rd_n` low and a write drives `pb_wr_n` low, for exactly WAITS consecutive cycles. The two strobes are never low together.
- R5: `cpu_hold` rises combinationally in the idle cycle in which a peripheral access arrives. It stays high through every strobe cycle and is low in the completion cycle, where the strobe is already inactive. A peripheral access therefore holds for WAITS+1 cycles.
- R6: A peripheral read samples `pb_dq_i` at the clock edge that ends the last strobe cycle. It presents bits 7:0 on `cpu_rdata` in the completion cycle and loads bits 15:8 into the holding register.
- R7: A holding-register read returns the register on `cpu_rdata` in the same cycle. A holding-register write loads `cpu_wdata` into the register at the clock edge.
- R8: During a peripheral write, `pb_dq_o` carries the holding register in bits 15:8 and the latched `cpu_wdata` in bits 7:0.
- R9: `pb_dq_oe` is high exactly while `pb_wr_n` is low, and low at all other times.
- R10: `cpu_sel` is ignored in the completion cycle. A new access is accepted only in the following idle cycle, even if `cpu_sel` never drops.
- R11: `cpu_rdata` is 0 except in a read completion cycle and during a holding-register read.
- R12: Synchronous reset `rst` returns the bridge to idle: strobes high, all selects inactive, hold low, output enable low and holding register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Window select from the system decoder |
| cpu_addr | input | 8 | Offset within the window |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | CPU_DW | Processor write data |
| cpu_rdata | output | CPU_DW | Processor read data |
| cpu_hold | output | 1 | Freezes the processor cycle |
| pb_rd_n | output | 1 | Peripheral read strobe, active low |
| pb_wr_n | output | 1 | Peripheral write strobe, active low |
| pb_reg | output | 5 | Peripheral register address |
| pb_dq_o | output | 2*CPU_DW | Peripheral data out |
| pb_dq_i | input | 2*CPU_DW | Peripheral data in |
| pb_dq_oe | output | 1 | Peripheral data output enable |
| dev_sel | output | 4 | Region selects, active high |
| ide_sel_n | output | 2 | Disk register-bank selects, active low |

## Verification
The bench builds the bridge with WAITS=4 and CPU_DW=8, which gives a 16-bit peripheral bus and five-cycle held accesses. The long strobe lets the bench see that the inputs are ignored mid-cycle, that the output enable matches the write strobe on every cycle, and that back-to-back accesses with `cpu_sel` held high still pass through an idle cycle. Every region and both disk select lines are visited, and the holding register is exercised in both directions against both read and write peripheral cycles.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    PB_IDLE   = 2'd0,
    PB_STROBE = 2'd1,
    PB_DONE   = 2'd2
  } pb_state_e;

  localparam int NUM_REGIONS = 4;
  localparam int REG_AW      = 5;

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int WAITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_sel,
  input  logic is_periph,
  output logic launch,
  output logic sample,
  output logic busy,
  output logic idle,
  output logic done_cyc,
  output logic hold
);

  localparam int CW = (WAITS > 1) ? $clog2(WAITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAITS - 1);

  pb_state_e st;
  logic [CW-1:0] cnt;

  assign idle     = (st == PB_IDLE);
  assign busy     = (st == PB_STROBE);
  assign done_cyc = (st == PB_DONE);
  assign launch   = idle && cpu_sel && is_periph;
  assign sample   = busy && (cnt == LAST);
  assign hold     = launch || busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PB_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PB_IDLE: begin
          if (launch) begin
            st  <= PB_STROBE;
            cnt <= '0;
          end
        end
        PB_STROBE: begin
          if (cnt == LAST) st <= PB_DONE;
          else             cnt <= cnt + 1'b1;
        end
        PB_DONE: st <= PB_IDLE;
        default: st <= PB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbus_lanes.sv
module pbus_lanes #(
  parameter int CPU_DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_sel,
  input  logic [7:0]          cpu_addr,
  input  logic                cpu_rd,
  input  logic [CPU_DW-1:0]   cpu_wdata,
  input  logic                launch,
  input  logic                sample,
  input  logic                idle,
  input  logic                done_cyc,
  input  logic [2*CPU_DW-1:0] pb_dq_i,
  output logic [6:0]          loc_q,
  output logic                rd_q,
  output logic                oe_q,
  output logic [CPU_DW-1:0]   cpu_rdata,
  output logic [2*CPU_DW-1:0] pb_dq_o
);

  logic [CPU_DW-1:0] upper_q;
  logic [CPU_DW-1:0] wlo_q;
  logic [CPU_DW-1:0] rlo_q;
  logic              hreg_acc;

  assign hreg_acc = idle && cpu_sel && cpu_addr[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q   <= '0;
      rd_q    <= 1'b1;
      oe_q    <= 1'b0;
      upper_q <= '0;
      wlo_q   <= '0;
      rlo_q   <= '0;
    end else begin
      if (launch) begin
        loc_q <= {cpu_addr[7:6], cpu_addr[4:0]};
        rd_q  <= cpu_rd;
        wlo_q <= cpu_wdata;
        oe_q  <= !cpu_rd;
      end else if (sample) begin
        oe_q <= 1'b0;
      end
      if (sample && rd_q) begin
        rlo_q   <= pb_dq_i[CPU_DW-1:0];
        upper_q <= pb_dq_i[2*CPU_DW-1:CPU_DW];
      end else if (hreg_acc && !cpu_rd) begin
        upper_q <= cpu_wdata;
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (done_cyc && rd_q)        cpu_rdata = rlo_q;
    else if (hreg_acc && cpu_rd) cpu_rdata = upper_q;
  end

  assign pb_dq_o = {upper_q, wlo_q};

endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
  import pbus_pkg::*;
(
  input  logic                   active,
  input  logic [6:0]             loc,
  output logic [NUM_REGIONS-1:0] dev_sel,
  output logic [1:0]             ide_sel_n,
  output logic [REG_AW-1:0]      reg_addr
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign dev_sel[g] = active && (loc[6:5] == 2'(g));
  end

  assign ide_sel_n[0] = !(dev_sel[0] && !loc[4]);
  assign ide_sel_n[1] = !(dev_sel[0] && loc[4]);
  assign reg_addr     = loc[4:0];

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int WAITS  = 4,
  parameter int CPU_DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_sel,
  input  logic [7:0]          cpu_addr,
  input  logic                cpu_rd,
  input  logic [CPU_DW-1:0]   cpu_wdata,
  output logic [CPU_DW-1:0]   cpu_rdata,
  output logic                cpu_hold,
  output logic                pb_rd_n,
  output logic                pb_wr_n,
  output logic [4:0]          pb_reg,
  output logic [2*CPU_DW-1:0] pb_dq_o,
  input  logic [2*CPU_DW-1:0] pb_dq_i,
  output logic                pb_dq_oe,
  output logic [3:0]          dev_sel,
  output logic [1:0]          ide_sel_n
);

  logic launch, sample, busy, idle, done_cyc;
  logic [6:0] loc_q;
  logic rd_q;

  pbus_seq #(.WAITS(WAITS)) u_seq (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .is_periph(!cpu_addr[5]),
    .launch(launch), .sample(sample), .busy(busy), .idle(idle),
    .done_cyc(done_cyc), .hold(cpu_hold)
  );

  pbus_lanes #(.CPU_DW(CPU_DW)) u_lanes (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .launch(launch),
    .sample(sample), .idle(idle), .done_cyc(done_cyc), .pb_dq_i(pb_dq_i),
    .loc_q(loc_q), .rd_q(rd_q), .oe_q(pb_dq_oe), .cpu_rdata(cpu_rdata),
    .pb_dq_o(pb_dq_o)
  );

  pbus_decode u_dec (
    .active(busy), .loc(loc_q), .dev_sel(dev_sel),
    .ide_sel_n(ide_sel_n), .reg_addr(pb_reg)
  );

  assign pb_rd_n = !(busy && rd_q);
  assign pb_wr_n = !(busy && !rd_q);

endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int WAITS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cpu_hold,
  input logic       pb_rd_n,
  input logic       pb_wr_n,
  input logic       pb_dq_oe,
  input logic [3:0] dev_sel,
  input logic [1:0] ide_sel_n
);

  logic strobe_on;
  int   run_len;

  assign strobe_on = !pb_rd_n || !pb_wr_n;

  always_ff @(posedge clk) begin
    if (rst)            run_len <= 0;
    else if (strobe_on) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!pb_rd_n && !pb_wr_n));

  // R4
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_on && $past(strobe_on)) |-> (run_len == WAITS));

  // R9
  oe_match_chk: assert property (@(posedge clk) disable iff (rst)
    pb_dq_oe == !pb_wr_n);

  // R1
  region_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_sel) && ((dev_sel != 4'b0) == strobe_on));

  // R2
  ide_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ide_sel_n != 2'b00);

  // R5
  hold_cover_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_on |-> cpu_hold);

  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_on && $past(strobe_on)) |-> !cpu_hold);

endmodule

bind pbus_bridge pbus_bridge_chk #(.WAITS(WAITS)) u_chk (
  .clk(clk), .rst(rst), .cpu_hold(cpu_hold), .pb_rd_n(pb_rd_n),
  .pb_wr_n(pb_wr_n), .pb_dq_oe(pb_dq_oe), .dev_sel(dev_sel),
  .ide_sel_n(ide_sel_n)
);

// File: tb/test_pbus_bridge.sv
module test_pbus_bridge;

  localparam int W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_sel = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic        cpu_rd = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_hold;
  logic        pb_rd_n, pb_wr_n, pb_dq_oe;
  logic [4:0]  pb_reg;
  logic [15:0] pb_dq_o;
  logic [15:0] pb_dq_i = '0;
  logic [3:0]  dev_sel;
  logic [1:0]  ide_sel_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pbus_bridge #(.WAITS(W), .CPU_DW(8)) i_pbus_bridge (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_hold(cpu_hold), .pb_rd_n(pb_rd_n), .pb_wr_n(pb_wr_n),
    .pb_reg(pb_reg), .pb_dq_o(pb_dq_o), .pb_dq_i(pb_dq_i),
    .pb_dq_oe(pb_dq_oe), .dev_sel(dev_sel), .ide_sel_n(ide_sel_n)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: ph 0 idle, >0 strobe cycles left, -1 completion
  int         ph = 0;
  logic [7:0] m_addr = '0, m_wlo = '0, m_hreg = '0, m_rlo = '0;
  bit         m_rd = 1;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; m_hreg = '0;
    end else if (ph == 0) begin
      if (cpu_sel && !cpu_addr[5]) begin
        m_addr = cpu_addr; m_rd = cpu_rd; m_wlo = cpu_wdata; ph = W;
      end else if (cpu_sel && !cpu_rd) begin
        m_hreg = cpu_wdata;
      end
    end else if (ph > 0) begin
      if (ph == 1) begin
        if (m_rd) begin m_rlo = pb_dq_i[7:0]; m_hreg = pb_dq_i[15:8]; end
        ph = -1;
      end else ph = ph - 1;
    end else ph = 0;
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit act;
      logic [7:0] e_rdata;
      logic [3:0] e_dev;
      logic [1:0] e_ide;
      act = (ph > 0);
      check(cpu_hold == ((ph == 0 && cpu_sel && !cpu_addr[5]) || act),
            "R5 hold", 32'(cpu_hold), 32'((ph == 0 && cpu_sel && !cpu_addr[5]) || act));
      check(pb_rd_n == !(act && m_rd), "R4 rd strobe", 32'(pb_rd_n), 32'(!(act && m_rd)));
      check(pb_wr_n == !(act && !m_rd), "R4 wr strobe", 32'(pb_wr_n), 32'(!(act && !m_rd)));
      e_dev = act ? (4'b1 << m_addr[7:6]) : 4'b0;
      check(dev_sel == e_dev, "R1 dev_sel", 32'(dev_sel), 32'(e_dev));
      e_ide = (act && m_addr[7:6] == 2'b00) ? (m_addr[4] ? 2'b01 : 2'b10) : 2'b11;
      check(ide_sel_n == e_ide, "R2 ide_sel_n", 32'(ide_sel_n), 32'(e_ide));
      if (act) check(pb_reg == m_addr[4:0], "R3 pb_reg", 32'(pb_reg), 32'(m_addr[4:0]));
      check(pb_dq_oe == (act && !m_rd), "R9 oe", 32'(pb_dq_oe), 32'(act && !m_rd));
      if (act && !m_rd)
        check(pb_dq_o == {m_hreg, m_wlo}, "R8 dq_o", 32'(pb_dq_o), 32'({m_hreg, m_wlo}));
      e_rdata = 8'h00;
      if (ph == -1 && m_rd) e_rdata = m_rlo;
      else if (ph == 0 && cpu_sel && cpu_addr[5] && cpu_rd) e_rdata = m_hreg;
      check(cpu_rdata == e_rdata, "R11 rdata", 32'(cpu_rdata), 32'(e_rdata));
    end
  end

  // Drives one access; returns read data and the number of held cycles.
  task automatic access(input logic [7:0] a, input bit rd, input logic [7:0] wd,
                        input logic [15:0] dqi, input bit keep,
                        output logic [7:0] rdata, output int held);
    @(posedge clk); #1;
    cpu_sel = 1'b1; cpu_addr = a; cpu_rd = rd; cpu_wdata = wd; pb_dq_i = dqi;
    held = 0;
    forever begin
      @(negedge clk);
      if (!cpu_hold) break;
      held++;
    end
    rdata = cpu_rdata;
    if (!keep) begin
      @(posedge clk); #1;
      cpu_sel = 1'b0; cpu_wdata = 8'hxx ^ 8'hxx;
    end
  endtask

  initial begin
    logic [7:0] rd;
    int held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12
    check(cpu_hold == 0 && pb_rd_n && pb_wr_n && dev_sel == 0 && ide_sel_n == 2'b11
          && !pb_dq_oe, "R12 reset outputs",
          32'({cpu_hold, pb_rd_n, pb_wr_n, dev_sel, ide_sel_n, pb_dq_oe}),
          32'({1'b0, 1'b1, 1'b1, 4'b0, 2'b11, 1'b0}));
    @(posedge clk); #1; rst = 1'b0;

    access(8'h20, 1, 8'h00, 16'h0, 0, rd, held);
    check(rd == 8'h00, "R12 holding reg cleared", 32'(rd), 32'h0);

    access(8'h20, 0, 8'hA5, 16'h0, 0, rd, held);
    check(held == 0, "R3 holding write no hold", 32'(held), 32'h0);
    access(8'h3F, 1, 8'h00, 16'h0, 0, rd, held);
    check(rd == 8'hA5, "R7 holding readback", 32'(rd), 32'hA5);

    access(8'h03, 0, 8'h3C, 16'hFFFF, 0, rd, held);
    check(held == W + 1, "R5 write held cycles", 32'(held), 32'(W + 1));
    access(8'h13, 0, 8'h11, 16'h0, 0, rd, held);
    access(8'h45, 0, 8'h22, 16'h0, 0, rd, held);
    access(8'h8A, 0, 8'h33, 16'h0, 0, rd, held);
    access(8'hDF, 0, 8'h44, 16'h0, 0, rd, held);

    access(8'h07, 1, 8'h00, 16'h1234, 0, rd, held);
    check(rd == 8'h34, "R6 read low byte", 32'(rd), 32'h34);
    check(held == W + 1, "R5 read held cycles", 32'(held), 32'(W + 1));
    access(8'h20, 1, 8'h00, 16'h0, 0, rd, held);
    check(rd == 8'h12, "R6 upper byte in holding reg", 32'(rd), 32'h12);

    access(8'hC1, 1, 8'h00, 16'hBEEF, 0, rd, held);
    check(rd == 8'hEF, "R6 region 3 read", 32'(rd), 32'hEF);
    access(8'h10, 0, 8'h5A, 16'h0, 0, rd, held);
    access(8'hE0, 1, 8'h00, 16'h0, 0, rd, held);
    check(rd == 8'hBE, "R7 holding after read", 32'(rd), 32'hBE);

    // R10: back-to-back with cpu_sel held high through completion
    access(8'h52, 1, 8'h00, 16'hCAFE, 1, rd, held);
    check(rd == 8'hFE, "R10 first of pair", 32'(rd), 32'hFE);
    access(8'h91, 1, 8'h00, 16'h7788, 1, rd, held);
    check(rd == 8'h88, "R10 second of pair", 32'(rd), 32'h88);
    check(held == W + 1, "R10 second pair held", 32'(held), 32'(W + 1));
    access(8'h21, 1, 8'h00, 16'h0, 0, rd, held);
    check(rd == 8'h77, "R7 holding after pair", 32'(rd), 32'h77);

    repeat (4) @(posedge clk);
    #1;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule